// File: doc/BRIEF.md
# Sinusoidal Reference Sweep Generator

This block produces the digital sine wave that a stack of level-shifted triangular carriers is compared against in a multilevel modulator. It walks a constant sample table that holds one full sine period. Each entry is held for a fixed number of system clocks, so the fundamental frequency is the clock divided by the product of hold count and table length. With a 50 MHz clock, 500 entries and a hold of 1666 clocks, the reference runs at about 60 Hz.

The table is computed at elaboration and stored offset-binary, so every sample is non-negative. Its lowest value is 0 and its highest value is the full height of the carrier stack, which is the carrier count times the carrier step (26 × 350 = 9100 by default). A comparator bank can therefore take the samples directly. Each time a new entry is shown, a strobe pulses for one clock, so downstream logic can latch or count updates. An enable input freezes the sweep without losing its place.

Top module: `sine_ref_gen`

## Requirements
- R1: A synchronous reset clears the hold counter and table index. In the first cycle after reset the sample output shows table entry 0 (value 0) and the strobe is low.
- R2: While enable is high, each table entry stays on the output for exactly HOLD_CYCLES enabled clock cycles. The first entry after reset is held for the same count.
- R3: The strobe is high for exactly one clock, in the first cycle that a new entry is shown, and at no other time.
- R4: The table index advances by one per update and wraps from TABLE_LEN-1 straight to 0, with no repeated or skipped sample. The sample shown after the wrap is entry 0, value 0.
- R5: The sample for index k equals round(PEAK·(1 − cos(2πk/TABLE_LEN))/2), within ±1 LSB. It is exactly 0 at k = 0 and exactly PEAK at k = TABLE_LEN/2 when TABLE_LEN is even.
- R6: PEAK = CARRIER_COUNT × CARRIER_STEP (9100 by default). The unsigned output never exceeds PEAK.
- R7: A cycle with enable low leaves the hold counter, index and output unchanged and gives no strobe. The count resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Sweep runs while high, freezes while low |
| refSample | output | $clog2(CARRIER_COUNT*CARRIER_STEP+1) (14 by default) | Current unsigned sine sample |
| refStrobe | output | 1 | One-clock pulse when a new sample is shown |

## Verification
Reset acts on the next clock edge, so the reset state is checked in the first half-cycle after that edge. An update fires on the edge that ends the HOLD_CYCLES-th enabled cycle. Sample and strobe change together on that same edge, because both come from one register stage behind the counter. The bench keeps a cycle-accurate count of enabled edges, drives inputs at the falling edge and compares outputs at the next falling edge. Every expected update therefore lands in exactly one sampled cycle. Enable gaps are checked in the cycle after each low-enable edge, and the wrap is checked on the strobe that brings the index back to 0.

// File: rtl/sinegen_pkg.sv
package sinegen_pkg;

  // Strobes passed from the sequencing control to the sample datapath
  typedef struct packed {
    logic advance;  // a new table entry is taken on this edge
    logic wrap;     // the entry taken is index 0 after the last index
  } seqCtrlT;

  // Offset-binary raised-cosine sample: round(peak*(1-cos(2*pi*k/len))/2)
  // Fixed point Q28, cosine by range reduction to [0,pi/2] and Taylor series.
  function automatic int sineTableEntry(input int k, input int len, input int peak);
    longint one;
    longint piQ;
    longint x;
    longint x2;
    longint term;
    longint cosv;
    longint num;
    int     kk;
    bit     neg;
    one  = longint'(1) <<< 28;
    piQ  = 64'sd843314857;
    kk   = (2 * k > len) ? (len - k) : k;
    neg  = (4 * kk > len);
    if (neg) x = ((longint'(len) - 2 * longint'(kk)) * piQ) / longint'(len);
    else     x = (2 * longint'(kk) * piQ) / longint'(len);
    x2   = (x * x) >>> 28;
    term = one;
    cosv = one;
    for (int j = 1; j <= 8; j++) begin
      term = -(((term * x2) >>> 28) / longint'((2 * j - 1) * (2 * j)));
      cosv = cosv + term;
    end
    if (neg) cosv = -cosv;
    num = longint'(peak) * (one - cosv) + one;
    num = num >>> 29;
    if (num < 0) num = 0;
    if (num > longint'(peak)) num = longint'(peak);
    return int'(num);
  endfunction

endpackage

// File: rtl/sine_seq_ctrl.sv
module sine_seq_ctrl
  import sinegen_pkg::*;
#(
  parameter int TABLE_LEN   = 500,
  parameter int HOLD_CYCLES = 1666,
  localparam int ADDR_W     = $clog2(TABLE_LEN),
  localparam int CNT_W      = $clog2(HOLD_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  output seqCtrlT           seqCtrl,
  output logic [ADDR_W-1:0] nextAddr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TABLE_LEN - 1);
  localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0]  holdCnt;
  logic [ADDR_W-1:0] addrQ;
  logic              terminal;
  logic              atLast;

  assign terminal = (holdCnt == LAST_CNT);
  assign atLast   = (addrQ == LAST_ADDR);
  assign nextAddr = atLast ? '0 : addrQ + ADDR_W'(1);

  always_comb begin
    seqCtrl.advance = enable && terminal;
    seqCtrl.wrap    = enable && terminal && atLast;
  end

  // Prescaler: reloads to zero on terminal count
  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt <= '0;
    end else if (enable) begin
      holdCnt <= terminal ? '0 : holdCnt + CNT_W'(1);
    end
  end

  // Table index: steps on each prescaler terminal count
  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
    end else if (seqCtrl.advance) begin
      addrQ <= nextAddr;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    holdCnt <= LAST_CNT);  // R2
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    addrQ <= LAST_ADDR);  // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    seqCtrl.advance && !seqCtrl.wrap |=> addrQ == $past(addrQ) + ADDR_W'(1));  // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    seqCtrl.wrap |=> addrQ == '0);  // R4
  AST_CTRL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(addrQ) && $stable(holdCnt));  // R7

endmodule

// File: rtl/sine_sample_path.sv
module sine_sample_path
  import sinegen_pkg::*;
#(
  parameter int TABLE_LEN   = 500,
  parameter int HOLD_CYCLES = 1666,
  parameter int PEAK        = 9100,
  localparam int ADDR_W     = $clog2(TABLE_LEN),
  localparam int SAMPLE_W   = $clog2(PEAK + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  seqCtrlT             seqCtrl,
  input  logic [ADDR_W-1:0]   nextAddr,
  output logic [SAMPLE_W-1:0] refSample,
  output logic                refStrobe
);

  logic [SAMPLE_W-1:0] romArr [TABLE_LEN];

  // Constant table, one elaboration-time entry per index
  for (genvar i = 0; i < TABLE_LEN; i++) begin : g_rom
    localparam int ENTRY = sineTableEntry(i, TABLE_LEN, PEAK);
    assign romArr[i] = SAMPLE_W'(ENTRY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refSample <= romArr[0];
      refStrobe <= 1'b0;
    end else begin
      refStrobe <= seqCtrl.advance;
      if (seqCtrl.advance) begin
        refSample <= romArr[nextAddr];
      end
    end
  end

  AST_VALUE_BOUND: assert property (@(posedge clk) disable iff (rst)
    refSample <= SAMPLE_W'(PEAK));  // R6
  AST_OUT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !refStrobe && $stable(refSample));  // R7
  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
    seqCtrl.wrap |=> refStrobe && refSample == romArr[0]);  // R4

  if (HOLD_CYCLES > 1) begin : g_pulse_chk
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
      refStrobe |=> !refStrobe);  // R3
  end

endmodule

// File: rtl/sine_ref_gen.sv
module sine_ref_gen
  import sinegen_pkg::*;
#(
  parameter int TABLE_LEN     = 500,
  parameter int HOLD_CYCLES   = 1666,
  parameter int CARRIER_COUNT = 26,
  parameter int CARRIER_STEP  = 350,
  localparam int PEAK         = CARRIER_COUNT * CARRIER_STEP,
  localparam int SAMPLE_W     = $clog2(PEAK + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  output logic [SAMPLE_W-1:0] refSample,
  output logic                refStrobe
);

  localparam int ADDR_W = $clog2(TABLE_LEN);

  seqCtrlT           seqCtrl;
  logic [ADDR_W-1:0] nextAddr;

  sine_seq_ctrl #(
    .TABLE_LEN  (TABLE_LEN),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .seqCtrl (seqCtrl),
    .nextAddr(nextAddr)
  );

  sine_sample_path #(
    .TABLE_LEN  (TABLE_LEN),
    .HOLD_CYCLES(HOLD_CYCLES),
    .PEAK       (PEAK)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .seqCtrl  (seqCtrl),
    .nextAddr (nextAddr),
    .refSample(refSample),
    .refStrobe(refStrobe)
  );

endmodule

// File: tb/sim_sine_ref_gen.sv
module sim_sine_ref_gen;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int  LEN    = 500;
  localparam int  HOLD   = 16;
  localparam int  NCARR  = 26;
  localparam int  STEP   = 350;
  localparam int  PEAK   = NCARR * STEP;
  localparam int  SW     = $clog2(PEAK + 1);
  localparam real PI_R   = 3.14159265358979323846;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [SW-1:0] refSample;
  logic          refStrobe;

  int checks = 0;
  int fails  = 0;

  // bench model state
  int idx = 0;
  int cnt = 0;
  int enEdges = 0;
  bit expStrobe = 1'b0;
  logic [SW-1:0] prevSample = '0;

  always #2.5 clk = ~clk;

  sine_ref_gen #(
    .TABLE_LEN    (LEN),
    .HOLD_CYCLES  (HOLD),
    .CARRIER_COUNT(NCARR),
    .CARRIER_STEP (STEP)
  ) u0 (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .refSample(refSample),
    .refStrobe(refStrobe)
  );

  function automatic real expVal(input int k);
    return real'(PEAK) * (1.0 - $cos(2.0 * PI_R * real'(k) / real'(LEN))) / 2.0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One clock: drive at falling edge, model the rising edge, compare at next falling edge
  task automatic cycle(input logic enV, input logic rstV);
    real diff;
    enable = enV;
    rst    = rstV;
    prevSample = refSample;
    @(posedge clk);
    if (rstV) begin
      idx = 0; cnt = 0; enEdges = 0; expStrobe = 1'b0;
    end else if (enV) begin
      enEdges++;
      if (cnt == HOLD - 1) begin
        cnt = 0; idx = (idx + 1) % LEN; expStrobe = 1'b1;
      end else begin
        cnt++; expStrobe = 1'b0;
      end
    end else begin
      expStrobe = 1'b0;
    end
    @(negedge clk);
    if (rstV) begin
      check(refSample == '0, "R1 reset sample", int'(refSample), 0);
      check(refStrobe == 1'b0, "R1 reset strobe", int'(refStrobe), 0);
    end else begin
      check(refStrobe == expStrobe, "R3 strobe timing", int'(refStrobe), int'(expStrobe));
      diff = real'(refSample) - expVal(idx);
      if (diff < 0.0) diff = -diff;
      check(diff <= 1.0, "R5 sample value", int'(refSample), int'(expVal(idx) + 0.5));
      if (idx == 0)
        check(refSample == '0, "R5 exact minimum", int'(refSample), 0);
      if (idx == LEN / 2)
        check(refSample == SW'(PEAK), "R5 exact peak", int'(refSample), PEAK);
      check(int'(refSample) <= PEAK, "R6 bound", int'(refSample), PEAK);
      if (!enV) begin
        check(refSample == prevSample, "R7 frozen sample", int'(refSample), int'(prevSample));
        check(refStrobe == 1'b0, "R7 no strobe", int'(refStrobe), 0);
      end
      if (refStrobe) begin
        check(enEdges == HOLD, "R2 hold length", enEdges, HOLD);
        enEdges = 0;
        if (idx == 0)
          check(refSample == '0, "R4 wrap to entry 0", int'(refSample), 0);
      end
    end
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1);
    // R2 R3 R4 R5: two full periods with enable held high
    for (int i = 0; i < 2 * LEN * HOLD + 5; i++) cycle(1'b1, 1'b0);
    // R7: irregular enable gaps
    for (int i = 0; i < 3000; i++) cycle(!((i % 37) < 5 || (i % 11) == 3), 1'b0);
    // R1: reset in the middle of a hold interval, then restart timing
    for (int i = 0; i < 7; i++) cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b1);
    for (int i = 0; i < LEN * HOLD + 40; i++) cycle(1'b1, 1'b0);
    // R7: long freeze then resume
    for (int i = 0; i < 50; i++) cycle(1'b0, 1'b0);
    for (int i = 0; i < 4 * HOLD; i++) cycle(1'b1, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule